// File: doc/BRIEF.md
# Data Cache Store Queue

This block is a small store buffer placed between a core's store and load ports and a single-ported data cache array. The core offers a store together with the result of that store's tag comparison in the same cycle. A store that hits is captured into a four-entry FIFO. A store that misses is acknowledged and then discarded. Buffered stores are written into the array one per cycle, oldest first. A drain takes place in any cycle where the core is not using the array for a load. Because of this, back-to-back stores run at full rate whenever loads leave the array free.

Loads search the queue while they read the array. For every byte lane, the youngest queued store that covers the byte supplies the value, and the array supplies every other byte. The merged result returns one cycle after the load is accepted. Suppose a load targets the same word as the oldest queued store. The block then drains that store in the same array access as the load: the array write and the read are combined, and forwarding covers the bytes that were just written. The load therefore pays no penalty.

Stores and loads use valid/ready. A transfer happens in a cycle where both valid and ready are high. A stalled requester must hold its request stable until it is accepted. `st_ready` is low only while the queue is full. `ld_ready` is low only while the queue is full and the load does not target the oldest entry's word. In that case the array is given to the drain.

Top module: `dcache_store_queue`

## Requirements
- R1: While reset is asserted and just after it is released, `st_ready` and `ld_ready` are high and `arr_en` and `ld_rvalid` are low.
- R2: A store handshake with `st_hit` high in the same cycle is captured. Its enabled bytes become visible to any load accepted in a later cycle, and they finally reach the array.
- R3: A store handshake with `st_hit` low changes neither the array nor any later load result.
- R4: If the queue is not empty and no load is offered, the oldest entry is written to the array in that cycle. The write uses `arr_we` high, `arr_addr` equal to the entry's word address, and `arr_be` bit i enabling byte i (`arr_wdata[8i+7:8i]`). Entries leave in the order in which they were stored.
- R5: `st_ready` is high whenever fewer than four entries are held. With no loads offered, a store is accepted in every cycle indefinitely.
- R6: The load result appears on `ld_rdata` with `ld_rvalid` high exactly one cycle after the load handshake. Each byte comes from the youngest queued store that enables it, or otherwise from the array.
- R7: A load to the word of the oldest queued entry is accepted even when the queue is full. In the same access, that entry is written to the array, and the load result still includes its bytes.
- R8: With four entries held, `st_ready` is low and a drain happens in every cycle. A load to another word sees `ld_ready` low in those cycles.
- R9: An accepted load drives `arr_en` high and `arr_addr` equal to `ld_addr`. The array returns the word's value from before any write in that same access on `arr_rdata` in the next cycle.
- R10: A store accepted in the same cycle as a load is not reflected in that load's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request can be taken |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | 64 | Store data |
| st_be | input | 8 | Store byte enables, bit i for byte i |
| st_hit | input | 1 | Tag comparison result for the store this cycle |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load request can be taken |
| ld_addr | input | ADDR_W | Load word address |
| ld_rvalid | output | 1 | Load result valid |
| ld_rdata | output | 64 | Merged load result |
| arr_en | output | 1 | Array access enable |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array word address |
| arr_wdata | output | 64 | Array write data |
| arr_be | output | 8 | Array write byte enables |
| arr_rdata | input | 64 | Array read data, one cycle after access |

## Verification
The bench builds the block with a 3-bit word address and the default depth of four. This gives eight words, so a sweep can visit every store-address and load-address pair. Those pairs cover the immediate store-then-load case, the same-cycle store-and-load case and forwarding across distinct words. With only four entries, the full condition is easy to reach on purpose. That allows the stall of stores, the forced drain during loads and the merged access on the oldest entry to be checked. A long pseudo-random mix that includes dropped stores is then run, followed by a comparison of the whole array image.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int DATA_W = 64;
  localparam int BE_W   = DATA_W / 8;

  // Overlay the lanes flagged in mask onto base.
  function automatic logic [DATA_W-1:0] overlay_bytes(
    input logic [DATA_W-1:0] base,
    input logic [DATA_W-1:0] over,
    input logic [BE_W-1:0]   mask
  );
    logic [DATA_W-1:0] r;
    r = base;
    for (int b = 0; b < BE_W; b++)
      if (mask[b]) r[8*b +: 8] = over[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/sq_fifo.sv
module sq_fifo import sq_pkg::*; #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 10,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic [BE_W-1:0]   push_be,
  input  logic              pop,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] age_addr [DEPTH],
  output logic [DATA_W-1:0] age_data [DEPTH],
  output logic [BE_W-1:0]   age_be   [DEPTH],
  output logic              age_vld  [DEPTH]
);
  // DEPTH must be a power of two so the pointers wrap on their own.
  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];
  logic [BE_W-1:0]   slot_be   [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        slot_addr[tail_q] <= push_addr;
        slot_data[tail_q] <= push_data;
        slot_be[tail_q]   <= push_be;
        tail_q            <= tail_q + 1'b1;
      end
      if (pop) head_q <= head_q + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // Present the entries ordered by age: index 0 is the oldest.
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [PTR_W-1:0] idx;
    assign idx         = head_q + PTR_W'(k);
    assign age_addr[k] = slot_addr[idx];
    assign age_data[k] = slot_data[idx];
    assign age_be[k]   = slot_be[idx];
    assign age_vld[k]  = CNT_W'(k) < count;
  end
endmodule

// File: rtl/sq_fwd.sv
module sq_fwd import sq_pkg::*; #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] look_addr,
  input  logic [ADDR_W-1:0] age_addr [DEPTH],
  input  logic [DATA_W-1:0] age_data [DEPTH],
  input  logic [BE_W-1:0]   age_be   [DEPTH],
  input  logic              age_vld  [DEPTH],
  output logic [DATA_W-1:0] fwd_data,
  output logic [BE_W-1:0]   fwd_mask
);
  // One search per byte lane; walking oldest to youngest lets the youngest win.
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    logic       lane_hit;
    logic [7:0] lane_byte;
    always_comb begin
      lane_hit  = 1'b0;
      lane_byte = '0;
      for (int k = 0; k < DEPTH; k++) begin
        if (age_vld[k] && age_addr[k] == look_addr && age_be[k][b]) begin
          lane_hit  = 1'b1;
          lane_byte = age_data[k][8*b +: 8];
        end
      end
    end
    assign fwd_mask[b]         = lane_hit;
    assign fwd_data[8*b +: 8]  = lane_byte;
  end
endmodule

// File: rtl/sq_arb.sv
module sq_arb #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 3
) (
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              merge,
  output logic              drain,
  output logic              ld_ready,
  output logic              st_ready
);
  logic full, nonempty;

  always_comb begin
    full     = count == CNT_W'(DEPTH);
    nonempty = count != '0;
    // A load to the oldest entry's word shares its access with that entry's write.
    merge    = ld_valid && nonempty && head_addr == ld_addr;
    // The array goes to the drain when idle, when shared, or when the queue is full.
    drain    = nonempty && (!ld_valid || merge || full);
    ld_ready = !full || merge;
    st_ready = !full;
  end
endmodule

// File: rtl/dcache_store_queue.sv
module dcache_store_queue import sq_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [63:0]       st_data,
  input  logic [7:0]        st_be,
  input  logic              st_hit,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_rvalid,
  output logic [63:0]       ld_rdata,
  output logic              arr_en,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [63:0]       arr_wdata,
  output logic [7:0]        arr_be,
  input  logic [63:0]       arr_rdata
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] age_addr [DEPTH];
  logic [DATA_W-1:0] age_data [DEPTH];
  logic [BE_W-1:0]   age_be   [DEPTH];
  logic              age_vld  [DEPTH];
  logic              push, merge, drain, ld_fire;
  logic [DATA_W-1:0] fwd_data, fwd_data_q;
  logic [BE_W-1:0]   fwd_mask, fwd_mask_q;
  logic              rvalid_q;

  assign push    = st_valid && st_ready && st_hit;
  assign ld_fire = ld_valid && ld_ready;

  sq_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fifo (
    .clk, .rst_n,
    .push, .push_addr(st_addr), .push_data(st_data), .push_be(st_be),
    .pop(drain), .count,
    .age_addr, .age_data, .age_be, .age_vld
  );

  sq_arb #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_arb (
    .count, .head_addr(age_addr[0]), .ld_valid, .ld_addr,
    .merge, .drain, .ld_ready, .st_ready
  );

  sq_fwd #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fwd (
    .look_addr(ld_addr), .age_addr, .age_data, .age_be, .age_vld,
    .fwd_data, .fwd_mask
  );

  // Single array port: a drain write (possibly shared with a load) or a plain read.
  always_comb begin
    arr_en    = drain || ld_fire;
    arr_we    = drain;
    arr_addr  = drain ? age_addr[0] : ld_addr;
    arr_wdata = age_data[0];
    arr_be    = drain ? age_be[0] : '0;
  end

  // Forwarded bytes are captured with the load and laid over the array word.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q   <= 1'b0;
      fwd_mask_q <= '0;
      fwd_data_q <= '0;
    end else begin
      rvalid_q <= ld_fire;
      if (ld_fire) begin
        fwd_mask_q <= fwd_mask;
        fwd_data_q <= fwd_data;
      end
    end
  end

  logic merge_unused;
  assign merge_unused = merge;

  assign ld_rvalid = rvalid_q;
  assign ld_rdata  = overlay_bytes(arr_rdata, fwd_data_q, fwd_mask_q);
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_ready,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic [ADDR_W-1:0] ld_addr,
  input logic              ld_rvalid,
  input logic              arr_en,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr
);
  assert_full_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> (arr_en && arr_we));

  assert_full_recovers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |=> st_ready);

  assert_load_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |-> (arr_en && arr_addr == ld_addr));

  assert_resp_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ld_rvalid == $past(ld_valid && ld_ready)));

  assert_write_in_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && ld_valid) |-> (!st_ready || arr_addr == ld_addr));
endmodule

bind dcache_store_queue sq_checker #(.ADDR_W(ADDR_W)) u_sq_chk (
  .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .ld_valid(ld_valid),
  .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_rvalid(ld_rvalid),
  .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/tb_dcache_store_queue.sv
module tb_dcache_store_queue;
  localparam int AW = 3;
  localparam int NW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          st_valid, st_ready, st_hit;
  logic [AW-1:0] st_addr;
  logic [63:0]   st_data;
  logic [7:0]    st_be;
  logic          ld_valid, ld_ready, ld_rvalid;
  logic [AW-1:0] ld_addr;
  logic [63:0]   ld_rdata;
  logic          arr_en, arr_we;
  logic [AW-1:0] arr_addr;
  logic [63:0]   arr_wdata, arr_rdata;
  logic [7:0]    arr_be;

  dcache_store_queue #(.ADDR_W(AW), .DEPTH(4)) dut (
    .clk, .rst_n, .st_valid, .st_ready, .st_addr, .st_data, .st_be, .st_hit,
    .ld_valid, .ld_ready, .ld_addr, .ld_rvalid, .ld_rdata,
    .arr_en, .arr_we, .arr_addr, .arr_wdata, .arr_be, .arr_rdata
  );

  function automatic logic [63:0] init_word(input int i);
    return (64'h0101010101010101 * 64'(i + 1)) ^ 64'hA55A_C33C_0FF0_9669;
  endfunction

  // Array model: read-first, one cycle read latency.
  logic [63:0] mem [NW];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= init_word(i);
      arr_rdata <= '0;
    end else if (arr_en) begin
      arr_rdata <= mem[arr_addr];
      if (arr_we)
        for (int b = 0; b < 8; b++)
          if (arr_be[b]) mem[arr_addr][8*b +: 8] <= arr_wdata[8*b +: 8];
    end
  end

  int nchk = 0, nerr = 0;
  bit finished = 0;
  logic [63:0]   gold [NW];
  logic [AW-1:0] qaddr [4];
  int            qcnt;
  logic [31:0]   rng = 32'h1234_5678;

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit sv, input logic [AW-1:0] sa, input logic [63:0] sd,
                      input logic [7:0] sbe, input bit sh, input bit lv, input logic [AW-1:0] la);
    bit full, mrg, exp_lr, exp_sr, exp_drain, lfire, sfire;
    logic [63:0] exp_ld;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sbe; st_hit = sh;
    ld_valid = lv; ld_addr = la;
    #5;
    full      = (qcnt == 4);
    mrg       = lv && qcnt > 0 && qaddr[0] == la;
    exp_sr    = !full;
    exp_lr    = !full || mrg;
    exp_drain = qcnt > 0 && (!lv || mrg || full);
    chk(st_ready == exp_sr, "R5/R8 st_ready", 64'(st_ready), 64'(exp_sr));
    chk(ld_ready == exp_lr, "R7/R8 ld_ready", 64'(ld_ready), 64'(exp_lr));
    chk(arr_we == exp_drain, "R4 drain", 64'(arr_we), 64'(exp_drain));
    if (exp_drain)
      chk(arr_addr == qaddr[0], "R4 fifo order", 64'(arr_addr), 64'(qaddr[0]));
    lfire  = lv && exp_lr;
    sfire  = sv && exp_sr;
    exp_ld = gold[la];
    if (lfire && !exp_drain)
      chk(arr_en && arr_addr == la, "R9 load access", 64'(arr_addr), 64'(la));
    @(posedge clk);
    if (exp_drain) begin
      for (int i = 0; i < 3; i++) qaddr[i] = qaddr[i+1];
      qcnt--;
    end
    if (sfire && sh) begin
      qaddr[qcnt] = sa;
      qcnt++;
      for (int b = 0; b < 8; b++) if (sbe[b]) gold[sa][8*b +: 8] = sd[8*b +: 8];
    end
    #1;
    chk(ld_rvalid == lfire, "R6 rvalid", 64'(ld_rvalid), 64'(lfire));
    if (lfire)
      chk(ld_rdata == exp_ld, "R6/R2/R3/R7/R10 load data", ld_rdata, exp_ld);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    rst_n = 0; st_valid = 0; st_addr = '0; st_data = '0; st_be = '0; st_hit = 0;
    ld_valid = 0; ld_addr = '0; qcnt = 0;
    for (int i = 0; i < 4; i++) qaddr[i] = '0;
    for (int i = 0; i < NW; i++) gold[i] = init_word(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(st_ready === 1'b1, "R1 st_ready", 64'(st_ready), 64'd1);
    chk(ld_ready === 1'b1, "R1 ld_ready", 64'(ld_ready), 64'd1);
    chk(arr_en === 1'b0, "R1 arr_en", 64'(arr_en), 64'd0);
    chk(ld_rvalid === 1'b0, "R1 ld_rvalid", 64'(ld_rvalid), 64'd0);
    rst_n = 1;
    #5;
    chk(st_ready === 1'b1 && arr_en === 1'b0, "R1 after release", 64'(arr_en), 64'd0);

    // R2/R6/R7: store then immediately load, every address pair
    for (int a = 0; a < NW; a++)
      for (int b = 0; b < NW; b++) begin
        d = {rng, ~rng}; rng = next_rng(rng);
        step(1, AW'(a), d, 8'(a * 29 + b * 11 + 1), 1, 0, '0);
        step(0, '0, '0, '0, 0, 1, AW'(b));
      end

    // R10: store and load to the same word in one cycle, then read again
    for (int a = 0; a < NW; a++) begin
      d = {~rng, rng}; rng = next_rng(rng);
      step(1, AW'(a), d, 8'hFF, 1, 1, AW'(a));
      step(0, '0, '0, '0, 0, 1, AW'(a));
    end

    // R3: missed store then load of that word
    for (int a = 0; a < NW; a++) begin
      step(1, AW'(a), 64'hDEAD_BEEF_0BAD_F00D, 8'hFF, 0, 0, '0);
      step(0, '0, '0, '0, 0, 1, AW'(a));
    end

    // R8: fill with loads to word 7, then stall; R7: merge on a full queue
    for (int rep = 0; rep < 4; rep++) begin
      for (int k = 0; k < 6; k++) begin
        d = {rng, rng}; rng = next_rng(rng);
        step(1, AW'(k % 4), d, 8'(8'h0F << (k % 5)), 1, 1, 3'd7);
      end
      step(1, 3'd5, 64'h1111_2222_3333_4444, 8'hFF, 1, 1, qaddr[0]);
      step(0, '0, '0, '0, 0, 1, 3'd5);
      for (int k = 0; k < 6; k++) step(0, '0, '0, '0, 0, 0, '0);
    end

    // R5: back-to-back stores with no loads
    for (int k = 0; k < 40; k++) begin
      d = {rng, ~rng}; rng = next_rng(rng);
      step(1, AW'(k), d, 8'(rng), 1, 0, '0);
    end

    // Mixed pseudo-random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      r = rng; rng = next_rng(rng);
      d = {rng, r}; rng = next_rng(rng);
      step(r[0] | r[1], AW'(r[4:2]), d, r[15:8], r[5] | r[6], r[7] & (r[16] | r[17]), AW'(r[20:18]));
    end

    for (int k = 0; k < 8; k++) step(0, '0, '0, '0, 0, 0, '0);
    // R2/R3/R4: final array image
    for (int i = 0; i < NW; i++)
      chk(mem[i] == gold[i], "R2/R3/R4 array image", mem[i], gold[i]);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule